// File: doc/BRIEF.md
# Score Table Configuration Loader

This block takes a byte stream from a host download port and turns it into configuration for a score save and restore engine. Bytes are taken only while a download is open on the configured index. The stream opens with a fixed 16-byte header of run-time timing values. An optional run of change-detection mask bytes follows the header, and after that comes a table of 8-byte entries. Each entry holds a RAM address, a length, a value to check at the start of the range and a value to check at its end.

The decoded header fields and the mask are presented as steady outputs. An entry is read back by placing its number on a select input. An entry counter and a configured flag tell the consumer how much of the table is valid. A parameter chooses whether entry lengths are one byte wide or two. The block never touches game RAM itself.

Top module: `score_cfg_loader`

## Requirements
- R1: After reset every header field reads zero, the entry count is zero, configured is low and every change-mask bit is 1.
- R2: A byte is taken only in a cycle where `dl_active` is high, `dl_index` equals `CFG_INDEX` (default 3) and `dl_we` is high. Writes with another index, or with the download closed, change no output.
- R3: The first 16 bytes of a download form the header. All multi-byte fields are most-significant byte first. The fields are: `hdr_mask_bytes` at byte 15, `hdr_pause_pad` at byte 14, `hdr_start_wait` at bytes 0–3, `hdr_check_wait` at 4–5, `hdr_check_hold` at 6–7, `hdr_write_hold` at 8–9, `hdr_write_repeats` at 10–11 and `hdr_repeat_wait` at 12–13.
- R4: Header byte 15 gives N, the number of mask bytes that come right after the header. Mask byte k is stored in `chg_mask[8*(MASK_MAX_BYTES-k)-1 -: 8]`, so the first mask byte sits in the top bits. Mask bytes at k ≥ `MASK_MAX_BYTES` are consumed but not stored. Every mask bit returns to 1 at the start of each accepted download.
- R5: When N is zero, the byte after the header is byte 0 of entry 0.
- R6: With `LEN_BYTES`=1, entry byte 0–3 is the address (MSB first), byte 4 the length, byte 5 the start value, byte 6 the end value, and byte 7 is ignored.
- R7: With `LEN_BYTES`=2, entry bytes 0–3 are the address, bytes 4–5 the length (MSB first), byte 6 the start value and byte 7 the end value.
- R8: `ent_count` rises by one when the eighth byte of an entry is taken. `configured` is high exactly when `ent_count` is non-zero. A partial entry is never counted.
- R9: The table holds 2^`ENT_AW` entries. Entries beyond that are dropped, `ent_count` stops at 2^`ENT_AW`, and the stored entries are left untouched.
- R10: The first cycle of an accepted download clears `ent_count` and `configured`.
- R11: `ent_addr`, `ent_len`, `ent_start` and `ent_end` show the fields of the entry chosen by `ent_sel` in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dl_active | input | 1 | Host download window open |
| dl_index | input | IDX_W | Index of the current download |
| dl_we | input | 1 | Byte strobe |
| dl_data | input | 8 | Download byte |
| ent_sel | input | ENT_AW | Entry to read back |
| hdr_start_wait | output | 32 | Delay before first check |
| hdr_check_wait | output | 16 | Wait between checks |
| hdr_check_hold | output | 16 | Settle time during checks |
| hdr_write_hold | output | 16 | Settle time during writes |
| hdr_write_repeats | output | 16 | Number of write passes |
| hdr_repeat_wait | output | 16 | Delay between write passes |
| hdr_pause_pad | output | 8 | Pause padding around RAM access |
| hdr_mask_bytes | output | 8 | Mask byte count from the header |
| chg_mask | output | 8*MASK_MAX_BYTES | Change-detection mask, first byte on top |
| ent_addr | output | 32 | Selected entry address |
| ent_len | output | 8*LEN_BYTES | Selected entry length |
| ent_start | output | 8 | Selected entry start check value |
| ent_end | output | 8 | Selected entry end check value |
| ent_count | output | ENT_AW+1 | Number of complete entries |
| configured | output | 1 | At least one entry stored |

## Verification
The bench feeds one stream to a one-byte-length instance and a two-byte-length instance, and checks each against its own field layout. A design that placed the length wrongly would shift the start and end values by one byte.

A mask longer than the mask register must still be skipped in full. A design that stopped counting at capacity would read the surplus mask bytes as entry data. With a zero mask count, a design that wrongly entered the mask phase would swallow the first entry.

A seventeenth entry is sent to check that the count saturates and that entry 0 is not overwritten. Writes to a foreign index and a partial trailing entry are checked to change nothing. A new download is checked to clear the count and restore the mask to all ones.

// File: rtl/scl_pkg.sv
package scl_pkg;
   localparam int HDR_BYTES = 16;
   localparam int HDR_BITS  = HDR_BYTES * 8;
   localparam int ENT_BYTES = 8;

   typedef enum logic [1:0] {
      PH_HDR  = 2'd0,
      PH_MASK = 2'd1,
      PH_ENT  = 2'd2
   } phase_e;
endpackage

// File: rtl/scl_seq.sv
// Byte sequencer: tracks which section of the stream the next byte belongs to.
module scl_seq
   import scl_pkg::*;
#(
   parameter int IDX_W     = 8,
   parameter int CFG_INDEX = 3,
   parameter int ENT_AW    = 4
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              dl_active,
   input  logic [IDX_W-1:0]  dl_index,
   input  logic              dl_we,
   input  logic [7:0]        dl_data,
   output logic              sess_start,
   output logic              wr_hdr,
   output logic [3:0]        hdr_pos,
   output logic              wr_mask,
   output logic [7:0]        mask_idx,
   output logic              wr_ent,
   output logic [2:0]        ent_off,
   output logic [ENT_AW:0]   ent_idx
);
   localparam int DEPTH = 1 << ENT_AW;

   logic   sess, sess_q, acc, table_full;
   phase_e phase;
   logic [7:0] mask_left;

   assign sess       = dl_active && (dl_index == IDX_W'(CFG_INDEX));
   assign sess_start = sess && !sess_q;
   assign acc        = sess && dl_we;
   assign table_full = (ent_idx == (ENT_AW+1)'(DEPTH));

   assign wr_hdr  = acc && (phase == PH_HDR);
   assign wr_mask = acc && (phase == PH_MASK);
   assign wr_ent  = acc && (phase == PH_ENT) && !table_full;

   always_ff @(posedge clk) begin
      if (rst) sess_q <= 1'b0;
      else     sess_q <= sess;
   end

   always_ff @(posedge clk) begin
      if (rst || !sess) begin
         phase     <= PH_HDR;
         hdr_pos   <= '0;
         mask_left <= '0;
         mask_idx  <= '0;
         ent_off   <= '0;
         ent_idx   <= '0;
      end else if (acc) begin
         case (phase)
            PH_HDR: begin
               hdr_pos <= hdr_pos + 4'd1;
               if (hdr_pos == 4'(HDR_BYTES - 1)) begin
                  mask_left <= dl_data;
                  phase     <= (dl_data == 8'd0) ? PH_ENT : PH_MASK;
               end
            end
            PH_MASK: begin
               mask_idx  <= mask_idx + 8'd1;
               mask_left <= mask_left - 8'd1;
               if (mask_left == 8'd1) phase <= PH_ENT;
            end
            PH_ENT: begin
               if (!table_full) begin
                  ent_off <= ent_off + 3'd1;
                  if (ent_off == 3'(ENT_BYTES - 1)) ent_idx <= ent_idx + 1'b1;
               end
            end
            default: phase <= PH_HDR;
         endcase
      end
   end

   // R2: outside a matching session the position returns home
   assert_idle_home_R2: assert property (@(posedge clk) disable iff (rst)
      !sess |=> (phase == PH_HDR && hdr_pos == 4'd0 && ent_idx == '0 && mask_idx == 8'd0));

   // R2: no strobe, no movement
   assert_no_strobe_hold_R2: assert property (@(posedge clk) disable iff (rst)
      (sess && !dl_we) |=> ($stable(phase) && $stable(hdr_pos) && $stable(ent_off)
                            && $stable(ent_idx) && $stable(mask_idx)));

   // R4: mask phase always has bytes outstanding
   assert_mask_live_R4: assert property (@(posedge clk) disable iff (rst)
      (phase == PH_MASK) |-> (mask_left != 8'd0));

   // R5: zero mask count goes straight to entries
   assert_hdr_to_ent_R5: assert property (@(posedge clk) disable iff (rst)
      (wr_hdr && hdr_pos == 4'd15 && dl_data == 8'd0) |=> (phase == PH_ENT));

   // R9: the entry index never passes the table depth
   assert_idx_bound_R9: assert property (@(posedge clk) disable iff (rst)
      ent_idx <= (ENT_AW+1)'(DEPTH));
endmodule

// File: rtl/scl_hdr.sv
// Header byte register and change-detection mask storage.
module scl_hdr
   import scl_pkg::*;
#(
   parameter int MASK_MAX_BYTES = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          sess_start,
   input  logic                          wr_hdr,
   input  logic [3:0]                    hdr_pos,
   input  logic                          wr_mask,
   input  logic [7:0]                    mask_idx,
   input  logic [7:0]                    dl_data,
   output logic [31:0]                   hdr_start_wait,
   output logic [15:0]                   hdr_check_wait,
   output logic [15:0]                   hdr_check_hold,
   output logic [15:0]                   hdr_write_hold,
   output logic [15:0]                   hdr_write_repeats,
   output logic [15:0]                   hdr_repeat_wait,
   output logic [7:0]                    hdr_pause_pad,
   output logic [7:0]                    hdr_mask_bytes,
   output logic [8*MASK_MAX_BYTES-1:0]   chg_mask
);
   localparam int MASK_BITS = 8 * MASK_MAX_BYTES;

   logic [HDR_BITS-1:0] hdr_q;

   for (genvar g = 0; g < HDR_BYTES; g++) begin : g_hdr_byte
      always_ff @(posedge clk) begin
         if (rst)
            hdr_q[HDR_BITS-1-8*g -: 8] <= 8'd0;
         else if (wr_hdr && hdr_pos == 4'(g))
            hdr_q[HDR_BITS-1-8*g -: 8] <= dl_data;
      end
   end

   assign hdr_start_wait    = hdr_q[127:96];
   assign hdr_check_wait    = hdr_q[95:80];
   assign hdr_check_hold    = hdr_q[79:64];
   assign hdr_write_hold    = hdr_q[63:48];
   assign hdr_write_repeats = hdr_q[47:32];
   assign hdr_repeat_wait   = hdr_q[31:16];
   assign hdr_pause_pad     = hdr_q[15:8];
   assign hdr_mask_bytes    = hdr_q[7:0];

   for (genvar g = 0; g < MASK_MAX_BYTES; g++) begin : g_mask_byte
      always_ff @(posedge clk) begin
         if (rst || sess_start)
            chg_mask[MASK_BITS-1-8*g -: 8] <= 8'hFF;
         else if (wr_mask && mask_idx == 8'(g))
            chg_mask[MASK_BITS-1-8*g -: 8] <= dl_data;
      end
   end

   // R3: header bytes only change on a header write
   assert_hdr_hold_R3: assert property (@(posedge clk) disable iff (rst)
      !wr_hdr |=> $stable(hdr_q));

   // R4: a new download restores the full mask
   assert_mask_fresh_R4: assert property (@(posedge clk) disable iff (rst)
      sess_start |=> (chg_mask == {MASK_BITS{1'b1}}));
endmodule

// File: rtl/scl_table.sv
// Entry table: per-entry field registers, count and configured flag.
module scl_table
   import scl_pkg::*;
#(
   parameter int ENT_AW    = 4,
   parameter int LEN_BYTES = 1
) (
   input  logic                    clk,
   input  logic                    rst,
   input  logic                    sess_start,
   input  logic                    wr_ent,
   input  logic [2:0]              ent_off,
   input  logic [ENT_AW:0]         ent_idx,
   input  logic [7:0]              dl_data,
   input  logic [ENT_AW-1:0]       ent_sel,
   output logic [31:0]             ent_addr,
   output logic [8*LEN_BYTES-1:0]  ent_len,
   output logic [7:0]              ent_start,
   output logic [7:0]              ent_end,
   output logic [ENT_AW:0]         ent_count,
   output logic                    configured
);
   localparam int DEPTH  = 1 << ENT_AW;
   localparam int LEN_W  = 8 * LEN_BYTES;
   localparam int ST_OFF = 4 + LEN_BYTES;
   localparam int EN_OFF = ST_OFF + 1;

   logic [31:0]      addr_rd [DEPTH];
   logic [LEN_W-1:0] len_rd  [DEPTH];
   logic [7:0]       st_rd   [DEPTH];
   logic [7:0]       en_rd   [DEPTH];

   logic ent_done;
   assign ent_done = wr_ent && (ent_off == 3'(ENT_BYTES - 1));

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      logic             hit;
      logic [31:0]      addr_q;
      logic [LEN_W-1:0] len_q;
      logic [7:0]       st_q, en_q;

      assign hit = wr_ent && (ent_idx == (ENT_AW+1)'(e));

      always_ff @(posedge clk) begin
         if (rst) begin
            addr_q <= '0;
            st_q   <= '0;
            en_q   <= '0;
         end else if (hit) begin
            case (ent_off)
               3'd0: addr_q[31:24] <= dl_data;
               3'd1: addr_q[23:16] <= dl_data;
               3'd2: addr_q[15:8]  <= dl_data;
               3'd3: addr_q[7:0]   <= dl_data;
               default: begin
                  if (ent_off == 3'(ST_OFF)) st_q <= dl_data;
                  if (ent_off == 3'(EN_OFF)) en_q <= dl_data;
               end
            endcase
         end
      end

      if (LEN_BYTES == 2) begin : g_len_wide
         always_ff @(posedge clk) begin
            if (rst)                         len_q       <= '0;
            else if (hit && ent_off == 3'd4) len_q[15:8] <= dl_data;
            else if (hit && ent_off == 3'd5) len_q[7:0]  <= dl_data;
         end
      end else begin : g_len_narrow
         always_ff @(posedge clk) begin
            if (rst)                         len_q <= '0;
            else if (hit && ent_off == 3'd4) len_q <= dl_data;
         end
      end

      assign addr_rd[e] = addr_q;
      assign len_rd[e]  = len_q;
      assign st_rd[e]   = st_q;
      assign en_rd[e]   = en_q;
   end

   assign ent_addr  = addr_rd[ent_sel];
   assign ent_len   = len_rd[ent_sel];
   assign ent_start = st_rd[ent_sel];
   assign ent_end   = en_rd[ent_sel];

   always_ff @(posedge clk) begin
      if (rst || sess_start) begin
         ent_count  <= '0;
         configured <= 1'b0;
      end else if (ent_done) begin
         ent_count  <= ent_count + 1'b1;
         configured <= 1'b1;
      end
   end

   // R8: count moves by at most one, or clears
   assert_count_step_R8: assert property (@(posedge clk) disable iff (rst)
      (ent_count == $past(ent_count)) || (ent_count == $past(ent_count) + 1'b1)
      || (ent_count == '0));

   // R8: configured tracks a non-empty table
   assert_cfg_track_R8: assert property (@(posedge clk) disable iff (rst)
      configured == (ent_count != '0));

   // R9: count never passes capacity
   assert_count_cap_R9: assert property (@(posedge clk) disable iff (rst)
      ent_count <= (ENT_AW+1)'(DEPTH));

   // R10: start of a download empties the table
   assert_start_clear_R10: assert property (@(posedge clk) disable iff (rst)
      sess_start |=> (ent_count == '0 && !configured));
endmodule

// File: rtl/score_cfg_loader.sv
module score_cfg_loader
   import scl_pkg::*;
#(
   parameter int CFG_INDEX      = 3,
   parameter int IDX_W          = 8,
   parameter int ENT_AW         = 4,
   parameter int LEN_BYTES      = 1,
   parameter int MASK_MAX_BYTES = 16
) (
   input  logic                          clk,
   input  logic                          rst,
   input  logic                          dl_active,
   input  logic [IDX_W-1:0]              dl_index,
   input  logic                          dl_we,
   input  logic [7:0]                    dl_data,
   input  logic [ENT_AW-1:0]             ent_sel,
   output logic [31:0]                   hdr_start_wait,
   output logic [15:0]                   hdr_check_wait,
   output logic [15:0]                   hdr_check_hold,
   output logic [15:0]                   hdr_write_hold,
   output logic [15:0]                   hdr_write_repeats,
   output logic [15:0]                   hdr_repeat_wait,
   output logic [7:0]                    hdr_pause_pad,
   output logic [7:0]                    hdr_mask_bytes,
   output logic [8*MASK_MAX_BYTES-1:0]   chg_mask,
   output logic [31:0]                   ent_addr,
   output logic [8*LEN_BYTES-1:0]        ent_len,
   output logic [7:0]                    ent_start,
   output logic [7:0]                    ent_end,
   output logic [ENT_AW:0]               ent_count,
   output logic                          configured
);
   initial begin : p_param_check
      assert (LEN_BYTES == 1 || LEN_BYTES == 2)
         else $error("LEN_BYTES must be 1 or 2");
      assert (ENT_AW >= 1 && ENT_AW <= 8)
         else $error("ENT_AW out of range");
      assert (MASK_MAX_BYTES >= 8 && MASK_MAX_BYTES % 8 == 0 && MASK_MAX_BYTES <= 255)
         else $error("MASK_MAX_BYTES must be a multiple of 8 up to 248");
      assert (IDX_W >= 1 && CFG_INDEX < (1 << IDX_W))
         else $error("CFG_INDEX does not fit IDX_W");
   end

   logic            sess_start, wr_hdr, wr_mask, wr_ent;
   logic [3:0]      hdr_pos;
   logic [7:0]      mask_idx;
   logic [2:0]      ent_off;
   logic [ENT_AW:0] ent_idx;

   scl_seq #(.IDX_W(IDX_W), .CFG_INDEX(CFG_INDEX), .ENT_AW(ENT_AW)) u_seq (
      .clk, .rst, .dl_active, .dl_index, .dl_we, .dl_data,
      .sess_start, .wr_hdr, .hdr_pos, .wr_mask, .mask_idx,
      .wr_ent, .ent_off, .ent_idx
   );

   scl_hdr #(.MASK_MAX_BYTES(MASK_MAX_BYTES)) u_hdr (
      .clk, .rst, .sess_start, .wr_hdr, .hdr_pos, .wr_mask, .mask_idx, .dl_data,
      .hdr_start_wait, .hdr_check_wait, .hdr_check_hold, .hdr_write_hold,
      .hdr_write_repeats, .hdr_repeat_wait, .hdr_pause_pad, .hdr_mask_bytes,
      .chg_mask
   );

   scl_table #(.ENT_AW(ENT_AW), .LEN_BYTES(LEN_BYTES)) u_table (
      .clk, .rst, .sess_start, .wr_ent, .ent_off, .ent_idx, .dl_data, .ent_sel,
      .ent_addr, .ent_len, .ent_start, .ent_end, .ent_count, .configured
   );
endmodule

// File: tb/score_cfg_loader_bench.sv
module score_cfg_loader_bench;
   localparam int CLK_PERIOD = 10;
   localparam int NVEC = 6;
   // raw 8-byte entries, sent MSB first
   localparam logic [63:0] VEC [NVEC] = '{
      64'h1234_A0C0_0511_2200, 64'h0000_8000_0244_55AA,
      64'hDEAD_BEEF_FF01_0203, 64'h0001_0000_107F_8081,
      64'h00C0_FFEE_0300_FF5A, 64'h7FFF_FFFF_1E9C_3D00
   };

   logic clk = 0, rst = 1, dl_active = 0, dl_we = 0;
   logic [7:0] dl_index = 0, dl_data = 0;
   logic [3:0] ent_sel = 0;

   logic [31:0] a_sw, b_sw, a_addr, b_addr;
   logic [15:0] a_cw, a_ch, a_wh, a_rc, a_rw, b_cw, b_ch, b_wh, b_rc, b_rw;
   logic [7:0]  a_pp, a_mb, b_pp, b_mb, a_st, a_en, b_st, b_en, a_len;
   logic [15:0] b_len;
   logic [127:0] a_mask, b_mask;
   logic [4:0]  a_cnt, b_cnt;
   logic        a_cfg, b_cfg;

   int n_chk = 0, n_fail = 0;
   bit done = 0;

   always #(CLK_PERIOD/2) clk = ~clk;

   score_cfg_loader u_score_cfg_loader (
      .clk, .rst, .dl_active, .dl_index, .dl_we, .dl_data, .ent_sel,
      .hdr_start_wait(a_sw), .hdr_check_wait(a_cw), .hdr_check_hold(a_ch),
      .hdr_write_hold(a_wh), .hdr_write_repeats(a_rc), .hdr_repeat_wait(a_rw),
      .hdr_pause_pad(a_pp), .hdr_mask_bytes(a_mb), .chg_mask(a_mask),
      .ent_addr(a_addr), .ent_len(a_len), .ent_start(a_st), .ent_end(a_en),
      .ent_count(a_cnt), .configured(a_cfg));

   score_cfg_loader #(.LEN_BYTES(2)) u_score_cfg_loader_w2 (
      .clk, .rst, .dl_active, .dl_index, .dl_we, .dl_data, .ent_sel,
      .hdr_start_wait(b_sw), .hdr_check_wait(b_cw), .hdr_check_hold(b_ch),
      .hdr_write_hold(b_wh), .hdr_write_repeats(b_rc), .hdr_repeat_wait(b_rw),
      .hdr_pause_pad(b_pp), .hdr_mask_bytes(b_mb), .chg_mask(b_mask),
      .ent_addr(b_addr), .ent_len(b_len), .ent_start(b_st), .ent_end(b_en),
      .ent_count(b_cnt), .configured(b_cfg));

   task automatic chk(input string req, input string what,
                      input logic [127:0] act, input logic [127:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   task automatic put(input logic [7:0] b);
      @(negedge clk); dl_data = b; dl_we = 1;
      @(negedge clk); dl_we = 0;
   endtask

   task automatic open_dl(input logic [7:0] idx);
      @(negedge clk); dl_active = 1; dl_index = idx;
      @(negedge clk);
   endtask

   task automatic close_dl();
      @(negedge clk); dl_active = 0;
      @(negedge clk);
   endtask

   task automatic send_hdr(input logic [31:0] sw, input logic [15:0] cw, ch, wh, rc, rw,
                           input logic [7:0] pp, mb);
      put(sw[31:24]); put(sw[23:16]); put(sw[15:8]); put(sw[7:0]);
      put(cw[15:8]); put(cw[7:0]); put(ch[15:8]); put(ch[7:0]);
      put(wh[15:8]); put(wh[7:0]); put(rc[15:8]); put(rc[7:0]);
      put(rw[15:8]); put(rw[7:0]); put(pp); put(mb);
   endtask

   task automatic send_ent(input logic [63:0] v);
      for (int k = 7; k >= 0; k--) put(v[8*k +: 8]);
   endtask

   // compare both instances' view of entry e against a raw 8-byte value
   task automatic chk_ent(input int e, input logic [63:0] v);
      ent_sel = 4'(e); #1;
      chk("R6 R11", "a addr",  a_addr, v[63:32]);
      chk("R6", "a len",   a_len,  v[31:24]);
      chk("R6", "a start", a_st,   v[23:16]);
      chk("R6", "a end",   a_en,   v[15:8]);
      chk("R7 R11", "b addr",  b_addr, v[63:32]);
      chk("R7", "b len",   b_len,  v[31:16]);
      chk("R7", "b start", b_st,   v[15:8]);
      chk("R7", "b end",   b_en,   v[7:0]);
   endtask

   initial begin : watchdog
      repeat (200000) @(posedge clk);
      if (!done) begin
         n_chk++; n_fail++;
         $display("FAIL watchdog all requirements: actual hung expected finished");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin : main
      logic [127:0] exp_mask;
      repeat (3) @(negedge clk);
      rst = 0;
      @(negedge clk);
      // R1 reset state
      chk("R1", "count", a_cnt, 0);
      chk("R1", "configured", a_cfg, 0);
      chk("R1", "mask", a_mask, {128{1'b1}});
      chk("R1", "start wait", a_sw, 0);
      chk("R1", "mask bytes", a_mb, 0);

      // download 1: header, 8 mask bytes, vector table walked by one loop
      open_dl(8'd3);
      send_hdr(32'h0A1B2C3D, 16'h0100, 16'h0002, 16'h0003, 16'h0001, 16'h0400, 8'h05, 8'd8);
      put(8'hF0); put(8'h0F); put(8'hAA); put(8'h55);
      put(8'hFF); put(8'h00); put(8'hC3); put(8'h3C);
      for (int i = 0; i < NVEC; i++) begin
         for (int k = 7; k >= 0; k--) begin
            put(VEC[i][8*k +: 8]);
            if (i == 0 && k == 1) begin
               chk("R8", "partial count", a_cnt, 0);
               chk("R8", "partial configured", a_cfg, 0);
            end
         end
         chk("R8", "count step", a_cnt, 5'(i + 1));
         chk("R8", "configured", a_cfg, 1);
      end
      close_dl();
      chk("R3", "start wait", a_sw, 32'h0A1B2C3D);
      chk("R3", "check wait", a_cw, 16'h0100);
      chk("R3", "check hold", a_ch, 16'h0002);
      chk("R3", "write hold", a_wh, 16'h0003);
      chk("R3", "repeats", a_rc, 16'h0001);
      chk("R3", "repeat wait", a_rw, 16'h0400);
      chk("R3", "pause pad", a_pp, 8'h05);
      chk("R3", "mask bytes", a_mb, 8'd8);
      chk("R4", "mask", a_mask, {64'hF00FAA55FF00C33C, {64{1'b1}}});
      for (int i = 0; i < NVEC; i++) chk_ent(i, VEC[i]);
      chk("R7", "b count", b_cnt, 5'(NVEC));

      // R2: strobes with the window closed, then a foreign index
      put(8'h77); put(8'h88);
      open_dl(8'd4);
      for (int k = 0; k < 30; k++) put(8'(k * 7 + 1));
      close_dl();
      chk("R2", "count kept", a_cnt, 5'(NVEC));
      chk("R2", "configured kept", a_cfg, 1);
      chk("R2", "start wait kept", a_sw, 32'h0A1B2C3D);
      chk("R2", "mask kept", a_mask, {64'hF00FAA55FF00C33C, {64{1'b1}}});
      chk_ent(0, VEC[0]);

      // R10: a new download clears count, configured and mask at its start
      open_dl(8'd3);
      chk("R10", "count cleared", a_cnt, 0);
      chk("R10", "configured cleared", a_cfg, 0);
      chk("R4", "mask refreshed", a_mask, {128{1'b1}});
      // R5: zero mask count, entry follows header directly
      send_hdr(32'h0, 16'h1, 16'h1, 16'h1, 16'h1, 16'h1, 8'h0, 8'd0);
      send_ent(VEC[2]);
      put(8'h11); put(8'h22); put(8'h33);
      close_dl();
      chk("R5", "count", a_cnt, 1);
      chk("R8", "partial not counted", b_cnt, 1);
      chk_ent(0, VEC[2]);

      // R4: mask longer than storage is skipped in full
      open_dl(8'd3);
      send_hdr(32'h0, 16'h1, 16'h1, 16'h1, 16'h1, 16'h1, 8'h0, 8'd24);
      for (int k = 0; k < 24; k++) put(8'(k + 1));
      send_ent(VEC[3]);
      close_dl();
      exp_mask = '0;
      for (int k = 0; k < 16; k++) exp_mask[127 - 8*k -: 8] = 8'(k + 1);
      chk("R4", "overlong mask", a_mask, exp_mask);
      chk("R4", "count after mask", a_cnt, 1);
      chk_ent(0, VEC[3]);

      // R9: seventeen entries into a sixteen-entry table
      open_dl(8'd3);
      send_hdr(32'h0, 16'h1, 16'h1, 16'h1, 16'h1, 16'h1, 8'h0, 8'd0);
      for (int e = 0; e < 17; e++)
         send_ent({32'(e * 16 + 1), 8'(e + 1), 8'(8'h10 + e), 8'(8'h20 + e), 8'h00});
      close_dl();
      chk("R9", "count saturates", a_cnt, 5'd16);
      chk("R9", "b count saturates", b_cnt, 5'd16);
      chk("R9", "configured", a_cfg, 1);
      chk_ent(0, {32'd1, 8'd1, 8'h10, 8'h20, 8'h00});
      chk_ent(15, {32'(15 * 16 + 1), 8'd16, 8'h1F, 8'h2F, 8'h00});

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule